// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the execute stage of a small 16-bit datapath. In one cycle it performs one of twelve two-operand operations or one of four single-operand operations: rotate through carry, arithmetic shift right, byte swap and sign extension. Each operation works on full words or on the low byte only. A caller presents a source, a destination, an operation code, a width select and the current carry flag with `in_valid`. One clock later the block returns the result and a write-back strobe. It also returns new overflow (V), negative (N), zero (Z) and carry (C) values, each paired with a bit that says whether the flag must be updated.

Each operation has its own flag policy. Some leave all four flags alone. Some force V low. Some derive C from Z. Compare and bit-test compute a result but never write it back. Decimal addition treats each nibble as one packed BCD digit. In byte mode, carry and sign come from the byte boundary and the upper half of the result is zero. The surrounding register file and sequencer use `wr_en` and `upd_mask` to decide what to commit. Stack handling, subroutine sequencing and memory access live outside this block.

Top module: `bw_alu`

## Requirements
- R1: `op_code` selects the operation: 0x04 MOV, 0x05 ADD, 0x06 ADDC, 0x07 SUBC, 0x08 SUB, 0x09 CMP, 0x0A DADD, 0x0B BIT, 0x0C BIC, 0x0D BIS, 0x0E XOR, 0x0F AND, 0x10 RRC, 0x11 SWPB, 0x12 RRA, 0x13 SXT. Outputs are registered: `out_valid` rises on the clock edge that samples `in_valid`, and the other outputs change on that same edge.
- R2: ADD computes dst+src, ADDC computes dst+src+C, SUB and CMP compute dst+~src+1, and SUBC computes dst+~src+C. For all five, C is the carry out of the active width, V flags signed overflow of the active width, N is the result MSB, Z flags a zero result, and `upd_mask` is 4'b1111.
- R3: CMP and BIT drive their computed value on `result`, but `wr_en` stays 0. Every other recognised operation asserts `wr_en`.
- R4: MOV (result = src), BIC (~src & dst), BIS (src | dst) and SWPB (bytes exchanged) write back with `upd_mask` = 4'b0000.
- R5: AND and BIT return src & dst. XOR returns src ^ dst. For all three, N and Z follow the result and C = !Z. V is 0 for AND and BIT. For XOR, V is set when both operand MSBs are 1.
- R6: DADD adds src, dst and C as packed BCD digits. C is the decimal carry out of the top digit of the active width, N and Z follow the result, and `upd_mask` is 4'b0111, so V is not updated.
- R7: With `byte_mode`=1, only bits 7:0 of the operands take part. N comes from bit 7, C comes from the carry into bit 8, V comes from byte overflow, and `result[15:8]` is 0. SWPB and SXT ignore `byte_mode` and always work on the full word.
- R8: RRC shifts right with the incoming C entering the MSB of the active width. RRA shifts right and keeps that MSB. For both, C takes the old bit 0, V is 0 and `upd_mask` is 4'b1111.
- R9: SXT copies bit 7 into bits 15:8, clears V, sets C = !Z and updates all four flags.
- R10: `upd_mask` bit order is {V,N,Z,C} = [3:0]. A flag output whose mask bit is 0 reads 0. In a cycle with `out_valid`=0, `wr_en`, `upd_mask`, `result` and all flag outputs are 0.
- R11: While `rst_n` is low, every output is 0.
- R12: Any other `op_code` (0x00–0x03, 0x14–0x1F) gives `result` 0, `wr_en` 0 and `upd_mask` 0, with `out_valid` still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op_code | input | 5 | Operation select |
| byte_mode | input | 1 | 1 = byte operation, 0 = word operation |
| carry_in | input | 1 | Current C flag |
| src_a | input | 16 | Source operand |
| dst_b | input | 16 | Destination operand |
| out_valid | output | 1 | Result registers hold a new result |
| wr_en | output | 1 | Result must be written to the destination |
| result | output | 16 | Operation result |
| upd_mask | output | 4 | Flag update enables, {V,N,Z,C} |
| flag_v | output | 1 | New overflow flag |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |

## Verification
The vector table covers the following cases:
- **Arithmetic operands.** Operand pairs sit exactly on the signed and unsigned boundaries (0x7FFF+1, 0xFFFF+1, 0x8000−1, equal compare operands). These separate carry from overflow and show whether the incoming carry is used or ignored in ADDC and SUBC.
- **Byte mode.** The same kinds of pairs run with nonzero upper bytes. This shows whether N, C, V and the cleared upper byte come from bit 7/8 rather than bit 15/16.
- **Decimal addition.** BCD cases with and without digit carries, including a full 9999+C roll to zero, separate decimal correction from binary addition.
- **Logic, rotate and unused codes.** Logic, rotate, swap and sign-extend cases with chosen low bits show whether C comes from bit 0 or from !Z. Unused codes show that nothing is written.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

    typedef enum logic [4:0] {
        OP_MOV  = 5'h04,
        OP_ADD  = 5'h05,
        OP_ADDC = 5'h06,
        OP_SUBC = 5'h07,
        OP_SUB  = 5'h08,
        OP_CMP  = 5'h09,
        OP_DADD = 5'h0A,
        OP_BIT  = 5'h0B,
        OP_BIC  = 5'h0C,
        OP_BIS  = 5'h0D,
        OP_XOR  = 5'h0E,
        OP_AND  = 5'h0F,
        OP_RRC  = 5'h10,
        OP_SWPB = 5'h11,
        OP_RRA  = 5'h12,
        OP_SXT  = 5'h13
    } alu_op_e;

    // Shift-unit selector, equal to op_code[1:0] of the single-operand group
    typedef enum logic [1:0] {
        SH_RRC  = 2'd0,
        SH_SWPB = 2'd1,
        SH_RRA  = 2'd2,
        SH_SXT  = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/bwalu_addsub.sv
// Binary adder returning the full carry chain top bit; callers pre-mask
// operands so the carry of a narrower width appears at a lower bit.
module bwalu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   sum
);
    assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
endmodule

// File: rtl/bwalu_dec.sv
// Packed BCD adder: one decimal cell per nibble, carries chained upward.
module bwalu_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic [W/4-1:0] dig_co
);
    localparam int NDIG = W / 4;

    logic [NDIG:0] chain;
    assign chain[0] = cin;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fix;
        always_comb begin
            raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, chain[g]};
            if (raw > 5'd9) begin
                fix = raw + 5'd6;
                chain[g+1] = 1'b1;
            end else begin
                fix = raw;
                chain[g+1] = 1'b0;
            end
        end
        assign sum[4*g +: 4] = fix[3:0];
        assign dig_co[g]     = chain[g+1];
    end
endmodule

// File: rtl/bwalu_shift.sv
// Single-operand unit: rotate through carry, arithmetic right, swap, sign extend.
module bwalu_shift
    import bw_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] dst,
    input  logic         half_sel,
    input  logic         cin,
    input  shift_kind_e  kind,
    output logic [W-1:0] res,
    output logic         lsb_out
);
    localparam int HALF = W / 2;

    always_comb begin
        unique case (kind)
            SH_RRC:  res = half_sel ? {{HALF{1'b0}}, cin, dst[HALF-1:1]}
                                    : {cin, dst[W-1:1]};
            SH_RRA:  res = half_sel ? {{HALF{1'b0}}, dst[HALF-1], dst[HALF-1:1]}
                                    : {dst[W-1], dst[W-1:1]};
            SH_SWPB: res = {dst[HALF-1:0], dst[W-1:HALF]};
            default: res = {{HALF{dst[HALF-1]}}, dst[HALF-1:0]};
        endcase
    end

    assign lsb_out = dst[0];
endmodule

// File: rtl/bw_alu.sv
module bw_alu
    import bw_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [4:0]   op_code,
    input  logic         byte_mode,
    input  logic         carry_in,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] dst_b,
    output logic         out_valid,
    output logic         wr_en,
    output logic [W-1:0] result,
    output logic [3:0]   upd_mask,
    output logic         flag_v,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c
);
    localparam int HALF  = W / 2;
    localparam int NDIG  = W / 4;
    localparam int HDIG  = HALF / 4;
    localparam logic [W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

    typedef struct packed {
        logic         valid;
        logic         wr;
        logic [W-1:0] res;
        logic [3:0]   mask;
        flags_t       flg;
    } out_state_t;

    out_state_t st_d, st_q;

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    // Operand conditioning
    logic [W-1:0] wmask, src_m, dst_m;
    assign wmask = byte_mode ? LOW_MASK : '1;
    assign src_m = src_a & wmask;
    assign dst_m = dst_b & wmask;

    function automatic logic top_bit(input logic [W-1:0] x, input logic half);
        return half ? x[HALF-1] : x[W-1];
    endfunction

    // Binary add/subtract path
    logic         sub_op;
    logic [W-1:0] add_b;
    logic         add_ci;
    logic [W:0]   add_sum;
    logic [W-1:0] add_res;
    logic         add_co, add_v;

    assign sub_op = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    assign add_b  = sub_op ? (~src_a & wmask) : src_m;
    assign add_ci = ((op == OP_ADDC) || (op == OP_SUBC)) ? carry_in
                  : ((op == OP_SUB)  || (op == OP_CMP));

    bwalu_addsub #(.W(W)) u_add (
        .a   (dst_m),
        .b   (add_b),
        .cin (add_ci),
        .sum (add_sum)
    );

    assign add_res = add_sum[W-1:0] & wmask;
    assign add_co  = byte_mode ? add_sum[HALF] : add_sum[W];
    assign add_v   = (top_bit(dst_m, byte_mode) == top_bit(add_b, byte_mode)) &&
                     (top_bit(add_res, byte_mode) != top_bit(dst_m, byte_mode));

    // Decimal path
    logic [W-1:0]    dec_sum;
    logic [NDIG-1:0] dec_dc;
    logic            dec_co;

    bwalu_dec #(.W(W)) u_dec (
        .a      (dst_m),
        .b      (src_m),
        .cin    (carry_in),
        .sum    (dec_sum),
        .dig_co (dec_dc)
    );
    assign dec_co = byte_mode ? dec_dc[HDIG-1] : dec_dc[NDIG-1];

    // Shift path
    logic [W-1:0] sh_res;
    logic         sh_lsb;

    bwalu_shift #(.W(W)) u_shift (
        .dst      (dst_m),
        .half_sel (byte_mode),
        .cin      (carry_in),
        .kind     (shift_kind_e'(op_code[1:0])),
        .res      (sh_res),
        .lsb_out  (sh_lsb)
    );

    // Shift path needs the unmasked operand for full-word ops
    logic [W-1:0] sh_full;
    assign sh_full = (op == OP_SWPB) ? {dst_b[HALF-1:0], dst_b[W-1:HALF]}
                                     : {{HALF{dst_b[HALF-1]}}, dst_b[HALF-1:0]};

    // Next-state computation
    logic         r_v, r_c, c_from_z, full_w, r_z, r_n;
    logic [W-1:0] r_res;
    logic         r_wr;
    logic [3:0]   r_mask;

    always_comb begin
        r_res    = '0;
        r_wr     = 1'b0;
        r_mask   = 4'b0000;
        r_v      = 1'b0;
        r_c      = 1'b0;
        c_from_z = 1'b0;
        full_w   = 1'b0;

        if (in_valid) begin
            case (op)
                OP_MOV: begin
                    r_res = src_m;
                    r_wr  = 1'b1;
                end
                OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP: begin
                    r_res  = add_res;
                    r_wr   = (op != OP_CMP);
                    r_mask = 4'b1111;
                    r_v    = add_v;
                    r_c    = add_co;
                end
                OP_DADD: begin
                    r_res  = dec_sum & wmask;
                    r_wr   = 1'b1;
                    r_mask = 4'b0111;
                    r_c    = dec_co;
                end
                OP_BIT, OP_AND: begin
                    r_res    = src_m & dst_m;
                    r_wr     = (op == OP_AND);
                    r_mask   = 4'b1111;
                    c_from_z = 1'b1;
                end
                OP_BIC: begin
                    r_res = ~src_m & dst_m;
                    r_wr  = 1'b1;
                end
                OP_BIS: begin
                    r_res = src_m | dst_m;
                    r_wr  = 1'b1;
                end
                OP_XOR: begin
                    r_res    = src_m ^ dst_m;
                    r_wr     = 1'b1;
                    r_mask   = 4'b1111;
                    r_v      = top_bit(src_m, byte_mode) & top_bit(dst_m, byte_mode);
                    c_from_z = 1'b1;
                end
                OP_RRC, OP_RRA: begin
                    r_res  = sh_res;
                    r_wr   = 1'b1;
                    r_mask = 4'b1111;
                    r_c    = sh_lsb;
                end
                OP_SWPB: begin
                    r_res  = sh_full;
                    r_wr   = 1'b1;
                    full_w = 1'b1;
                end
                OP_SXT: begin
                    r_res    = sh_full;
                    r_wr     = 1'b1;
                    r_mask   = 4'b1111;
                    c_from_z = 1'b1;
                    full_w   = 1'b1;
                end
                default: begin
                    r_res = '0;
                end
            endcase
        end

        r_z = (r_res == '0);
        r_n = full_w ? r_res[W-1] : top_bit(r_res, byte_mode);
        if (c_from_z) r_c = ~r_z;

        st_d.valid = in_valid;
        st_d.wr    = r_wr;
        st_d.res   = r_res;
        st_d.mask  = r_mask;
        st_d.flg   = flags_t'({r_v, r_n, r_z, r_c} & r_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Sanity use of the shift unit on full-word kinds keeps widths aligned
    assign out_valid = st_q.valid;
    assign wr_en     = st_q.wr;
    assign result    = st_q.res;
    assign upd_mask  = st_q.mask;
    assign flag_v    = st_q.flg.v;
    assign flag_n    = st_q.flg.n;
    assign flag_z    = st_q.flg.z;
    assign flag_c    = st_q.flg.c;

endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [4:0]   op_code,
    input logic         byte_mode,
    input logic         out_valid,
    input logic         wr_en,
    input logic [W-1:0] result,
    input logic [3:0]   upd_mask,
    input logic         flag_v,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c
);
    localparam int HALF = W / 2;

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && upd_mask == 4'b0000 && result == '0));

    assert_masked_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((!upd_mask[3] -> !flag_v) && (!upd_mask[2] -> !flag_n) &&
         (!upd_mask[1] -> !flag_z) && (!upd_mask[0] -> !flag_c)));

    assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_mask[1] |-> (flag_z == (result == '0)));

    assert_no_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_code) == 5'h09 || $past(op_code) == 5'h0B)) |-> !wr_en);

    assert_byte_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(byte_mode) && $past(op_code) != 5'h11 && $past(op_code) != 5'h13)
        |-> (result[W-1:HALF] == '0));

    assert_carry_not_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_code) == 5'h0B || $past(op_code) == 5'h0E ||
                       $past(op_code) == 5'h0F || $past(op_code) == 5'h13))
        |-> (flag_c == !flag_z));

    assert_unused_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_code) < 5'h04 || $past(op_code) > 5'h13))
        |-> (!wr_en && upd_mask == 4'b0000));

endmodule

bind bw_alu bw_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .byte_mode (byte_mode),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .result    (result),
    .upd_mask  (upd_mask),
    .flag_v    (flag_v),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c)
);

// File: tb/sim_bw_alu.sv
module sim_bw_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = 5'h00;
    logic        byte_mode = 1'b0;
    logic        carry_in = 1'b0;
    logic [15:0] src_a = 16'h0000;
    logic [15:0] dst_b = 16'h0000;
    logic        out_valid, wr_en;
    logic [15:0] result;
    logic [3:0]  upd_mask;
    logic        flag_v, flag_n, flag_z, flag_c;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    bw_alu #(.W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .byte_mode(byte_mode), .carry_in(carry_in), .src_a(src_a), .dst_b(dst_b),
        .out_valid(out_valid), .wr_en(wr_en), .result(result), .upd_mask(upd_mask),
        .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
    );

    // {req[4], op[5], byte, cin, src[16], dst[16], res[16], wr, mask[4], flags VNZC[4]}
    localparam int NV = 32;
    localparam logic [67:0] VEC [NV] = '{
        {4'd4,  5'h04, 1'b0, 1'b0, 16'h1234, 16'hFFFF, 16'h1234, 1'b1, 4'h0, 4'b0000}, // R4 MOV
        {4'd2,  5'h05, 1'b0, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 1'b1, 4'hF, 4'b1100}, // R2 signed ovf
        {4'd2,  5'h05, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'hF, 4'b0011}, // R2 carry, zero
        {4'd2,  5'h06, 1'b0, 1'b1, 16'h0001, 16'h0001, 16'h0003, 1'b1, 4'hF, 4'b0000}, // R2 ADDC
        {4'd2,  5'h08, 1'b0, 1'b0, 16'h0001, 16'h0003, 16'h0002, 1'b1, 4'hF, 4'b0001}, // R2 SUB no borrow
        {4'd2,  5'h08, 1'b0, 1'b1, 16'h0003, 16'h0001, 16'hFFFE, 1'b1, 4'hF, 4'b0100}, // R2 SUB borrow
        {4'd2,  5'h07, 1'b0, 1'b0, 16'h0001, 16'h0005, 16'h0003, 1'b1, 4'hF, 4'b0001}, // R2 SUBC C=0
        {4'd2,  5'h08, 1'b0, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 4'hF, 4'b1001}, // R2 SUB ovf
        {4'd3,  5'h09, 1'b0, 1'b0, 16'h0005, 16'h0005, 16'h0000, 1'b0, 4'hF, 4'b0011}, // R3 CMP equal
        {4'd6,  5'h0A, 1'b0, 1'b0, 16'h1234, 16'h5678, 16'h6912, 1'b1, 4'h7, 4'b0000}, // R6 DADD
        {4'd6,  5'h0A, 1'b0, 1'b1, 16'h9999, 16'h0000, 16'h0000, 1'b1, 4'h7, 4'b0011}, // R6 DADD roll
        {4'd6,  5'h0A, 1'b1, 1'b0, 16'h0055, 16'h0048, 16'h0003, 1'b1, 4'h7, 4'b0001}, // R6 DADD byte
        {4'd3,  5'h0B, 1'b0, 1'b0, 16'h00F0, 16'h0F0F, 16'h0000, 1'b0, 4'hF, 4'b0010}, // R3 BIT
        {4'd4,  5'h0C, 1'b0, 1'b1, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 4'h0, 4'b0000}, // R4 BIC
        {4'd4,  5'h0D, 1'b0, 1'b0, 16'h000F, 16'h1230, 16'h123F, 1'b1, 4'h0, 4'b0000}, // R4 BIS
        {4'd5,  5'h0E, 1'b0, 1'b0, 16'h8001, 16'h8000, 16'h0001, 1'b1, 4'hF, 4'b1001}, // R5 XOR
        {4'd5,  5'h0F, 1'b0, 1'b0, 16'h8F00, 16'hF0F0, 16'h8000, 1'b1, 4'hF, 4'b0101}, // R5 AND
        {4'd7,  5'h05, 1'b1, 1'b0, 16'h0012, 16'h1A8F, 16'h00A1, 1'b1, 4'hF, 4'b0100}, // R7 byte add
        {4'd7,  5'h05, 1'b1, 1'b0, 16'h00FF, 16'hAB01, 16'h0000, 1'b1, 4'hF, 4'b0011}, // R7 byte carry
        {4'd7,  5'h05, 1'b1, 1'b0, 16'h0001, 16'h007F, 16'h0080, 1'b1, 4'hF, 4'b1100}, // R7 byte ovf
        {4'd8,  5'h10, 1'b0, 1'b1, 16'h0000, 16'h0003, 16'h8001, 1'b1, 4'hF, 4'b0101}, // R8 RRC
        {4'd8,  5'h10, 1'b1, 1'b0, 16'h0000, 16'hFF02, 16'h0001, 1'b1, 4'hF, 4'b0000}, // R8 RRC byte
        {4'd8,  5'h12, 1'b0, 1'b0, 16'h0000, 16'h8001, 16'hC000, 1'b1, 4'hF, 4'b0101}, // R8 RRA
        {4'd8,  5'h12, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'h0000, 1'b1, 4'hF, 4'b0011}, // R8 RRA byte
        {4'd4,  5'h11, 1'b0, 1'b0, 16'h0000, 16'h12AB, 16'hAB12, 1'b1, 4'h0, 4'b0000}, // R4 SWPB
        {4'd7,  5'h11, 1'b1, 1'b0, 16'h0000, 16'h12AB, 16'hAB12, 1'b1, 4'h0, 4'b0000}, // R7 SWPB ignores byte
        {4'd9,  5'h13, 1'b0, 1'b0, 16'h0000, 16'h0080, 16'hFF80, 1'b1, 4'hF, 4'b0101}, // R9 SXT
        {4'd9,  5'h13, 1'b1, 1'b0, 16'h0000, 16'h1200, 16'h0000, 1'b1, 4'hF, 4'b0010}, // R9 SXT byte ignored
        {4'd12, 5'h00, 1'b0, 1'b1, 16'h1234, 16'h5678, 16'h0000, 1'b0, 4'h0, 4'b0000}, // R12 code 0x00
        {4'd12, 5'h1F, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 4'h0, 4'b0000}, // R12 code 0x1F
        {4'd5,  5'h0F, 1'b1, 1'b0, 16'h00F0, 16'h0080, 16'h0080, 1'b1, 4'hF, 4'b0101}, // R5 AND byte
        {4'd3,  5'h09, 1'b1, 1'b0, 16'h0001, 16'h0000, 16'h00FF, 1'b0, 4'hF, 4'b0100}  // R3 CMP byte
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R11: outputs stay zero during reset even with active inputs
        in_valid = 1'b1; op_code = 5'h05; src_a = 16'h1111; dst_b = 16'h2222;
        repeat (3) @(negedge clk);
        chk(11, {15'd0, out_valid}, 16'h0, "reset out_valid");
        chk(11, result, 16'h0, "reset result");
        chk(11, {11'd0, wr_en, upd_mask}, 16'h0, "reset wr/mask");
        chk(11, {12'd0, flag_v, flag_n, flag_z, flag_c}, 16'h0, "reset flags");
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle cycle
        chk(10, {15'd0, out_valid}, 16'h0, "idle out_valid");
        chk(10, {11'd0, wr_en, upd_mask}, 16'h0, "idle wr/mask");

        for (int i = 0; i < NV; i++) begin
            logic [67:0] v;
            v = VEC[i];
            in_valid  = 1'b1;
            op_code   = v[63:59];
            byte_mode = v[58];
            carry_in  = v[57];
            src_a     = v[56:41];
            dst_b     = v[40:25];
            @(negedge clk);
            chk(1, {15'd0, out_valid}, 16'h1, $sformatf("vec %0d out_valid", i)); // R1
            chk(int'(v[67:64]), result, v[24:9], $sformatf("vec %0d result", i));
            chk(int'(v[67:64]), {15'd0, wr_en}, {15'd0, v[8]}, $sformatf("vec %0d wr_en", i));
            chk(int'(v[67:64]), {12'd0, upd_mask}, {12'd0, v[7:4]}, $sformatf("vec %0d mask", i));
            chk(10, {12'd0, flag_v, flag_n, flag_z, flag_c}, {12'd0, v[3:0]},
                $sformatf("vec %0d flags", i)); // R10 masked flags read zero
        end

        // R1: dropping in_valid clears everything on the next edge
        in_valid = 1'b0;
        @(negedge clk);
        chk(1, {15'd0, out_valid}, 16'h0, "out_valid after drop");
        chk(10, {11'd0, wr_en, upd_mask}, 16'h0, "wr/mask after drop");
        chk(10, result, 16'h0, "result after drop");

        // R2: SUBC with carry set behaves as plain subtract
        in_valid = 1'b1; op_code = 5'h07; byte_mode = 1'b0; carry_in = 1'b1;
        src_a = 16'h0001; dst_b = 16'h0005;
        @(negedge clk);
        chk(2, result, 16'h0004, "SUBC C=1 result");

        // R7: byte MOV clears the upper byte
        op_code = 5'h04; byte_mode = 1'b1; src_a = 16'hBEEF;
        @(negedge clk);
        chk(7, result, 16'h00EF, "byte MOV result");

        // R11: asynchronous reset mid-stream
        #1 rst_n = 1'b0;
        #1;
        chk(11, {15'd0, out_valid}, 16'h0, "async reset out_valid");
        chk(11, result, 16'h0, "async reset result");
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule